// File: doc/BRIEF.md
# Data Lane Burst Sequencer

This block walks a single serial data lane from its low-power rest state through a complete high-speed burst and back again. A start pulse in the rest state launches the entry sequence: a request state, a bridge (prepare) state and a run of high-speed zeros. A fixed sync byte follows, then the payload bytes one bit per clock, least significant bit first. A trail that holds the inverse of the final bit comes next, and a low-power exit interval closes the burst. Every interval length comes from an input measured in system clock cycles, so firmware or a wrapper can meet the lane's minimum timings at any clock rate.

Payload arrives over a byte stream with valid and last flags. The block pulls one byte per eight payload cycles through a ready strobe. If no byte is offered when one is due and the last flag has not yet been seen, it flags an error and closes the burst cleanly. The symbolic line state it drives feeds a separate serializer model.

Top module: `dlane_burst_seq`

## Requirements
- R1: Out of reset and between bursts the lane shows the stop state (line code 0), busy is low, the error flag is low and ready is low.
- R2: A start pulse sampled in the stop state is followed, from the next cycle, by the request state (line code 1) for max(lpx,1) cycles, with busy high from that cycle until the end of the exit interval.
- R3: The request state is followed by the bridge state (line code 2) for max(prep,1) cycles.
- R4: The bridge state is followed by high-speed zero (line code 4) for max(zero,1) cycles.
- R5: The sync byte 8'hB8 is then sent least significant bit first, one bit per cycle, each 0 bit as line code 4 and each 1 bit as line code 5.
- R6: Each payload byte is sent least significant bit first right after the sync byte or the previous byte; ready is high in the final bit cycle of the sync byte or of a byte not flagged last, and the byte on the input is taken in that cycle when valid is high.
- R7: After the final bit sent, the lane holds the opposite bit (line code 5 after a 0, line code 4 after a 1) for max(trail,1) cycles.
- R8: After the trail the lane shows the stop state with busy still high for max(exit,lpx,1) cycles, then returns to rest.
- R9: An interval register of zero yields exactly one cycle for that phase, so the total busy time is the sum of the clamped intervals plus eight cycles per byte sent plus eight.
- R10: A start pulse while busy has no effect: the burst length and line sequence are unchanged and no new burst follows.
- R11: When ready is high and valid is low, the error flag is set, no further payload is sent and the trail starts at once; the flag stays set in rest and is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst request, sampled only in rest |
| byte_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | Payload byte present |
| byte_last_i | input | 1 | Payload byte is the final one of the burst |
| byte_rdy_o | output | 1 | Payload byte taken this cycle if valid |
| lpx_cyc_i | input | CNT_W | Low-power state length in cycles |
| prep_cyc_i | input | CNT_W | Bridge (prepare) length in cycles |
| zero_cyc_i | input | CNT_W | High-speed zero length in cycles |
| trail_cyc_i | input | CNT_W | Trail length in cycles |
| exit_cyc_i | input | CNT_W | Exit stop-state length in cycles |
| line_o | output | 3 | Symbolic line state code |
| busy_o | output | 1 | Burst in progress |
| err_o | output | 1 | Payload underrun seen in the last burst |

## Verification
The bench keeps the default counter width of 8 bits and drives the interval inputs with small values from 0 to 6. That brings every phase boundary, the zero-to-one clamp and the lpx floor on the exit interval within a few dozen cycles per burst. The payloads are chosen so that final bits of both polarities occur. This exercises both trail polarities, and the two underrun points (the first byte slot and a later slot) are each hit.

// File: rtl/dlane_pkg.sv
package dlane_pkg;
    typedef enum logic [2:0] {
        LN_STOP   = 3'd0,
        LN_REQ    = 3'd1,
        LN_BRIDGE = 3'd2,
        LN_HS0    = 3'd4,
        LN_HS1    = 3'd5
    } line_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_REQ, PH_PREP, PH_ZERO, PH_SYNC, PH_PAY, PH_TRAIL, PH_EXIT
    } phase_e;

    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hB8;
endpackage

// File: rtl/dlane_interval_timer.sv
module dlane_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (len_i == '0) ? '0 : len_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    // a phase loaded with a length above one cannot end in its first cycle
    assert_no_early_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i > CNT_W'(1)) |=> !done_o);
endmodule

// File: rtl/dlane_bit_shifter.sv
module dlane_bit_shifter
    import dlane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              end_o
);
    localparam int IDX_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.sh  = load_val_i;
            s_d.idx = '0;
        end else if (shift_i) begin
            s_d.sh  = s_q.sh >> 1;
            s_d.idx = s_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_o = s_q.sh[0];
    assign end_o = (s_q.idx == IDX_W'(BYTE_W - 1));

    // a freshly loaded byte starts at its first bit, so it is not at its end
    assert_fresh_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !end_o);
endmodule

// File: rtl/dlane_burst_seq.sv
module dlane_burst_seq
    import dlane_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       byte_i,
    input  logic             byte_valid_i,
    input  logic             byte_last_i,
    output logic             byte_rdy_o,
    input  logic [CNT_W-1:0] lpx_cyc_i,
    input  logic [CNT_W-1:0] prep_cyc_i,
    input  logic [CNT_W-1:0] zero_cyc_i,
    input  logic [CNT_W-1:0] trail_cyc_i,
    input  logic [CNT_W-1:0] exit_cyc_i,
    output logic [2:0]       line_o,
    output logic             busy_o,
    output logic             err_o
);
    typedef struct packed {
        phase_e phase;
        logic   fin;
        logic   prev;
        logic   err;
    } seq_t;

    seq_t s_d, s_q;

    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_len, exit_len;
    logic             sh_load, sh_shift, sh_bit, sh_end;
    logic [7:0]       sh_val;
    logic             take_slot;

    dlane_interval_timer #(.CNT_W(CNT_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .done_o (tmr_done)
    );

    dlane_bit_shifter i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (sh_val),
        .shift_i    (sh_shift),
        .bit_o      (sh_bit),
        .end_o      (sh_end)
    );

    assign exit_len  = (exit_cyc_i > lpx_cyc_i) ? exit_cyc_i : lpx_cyc_i;
    assign take_slot = sh_end && ((s_q.phase == PH_SYNC) ||
                                  (s_q.phase == PH_PAY && !s_q.fin));

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_len  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_val   = SYNC_BYTE;
        unique case (s_q.phase)
            PH_IDLE: if (start_i) begin
                s_d.phase = PH_REQ;
                s_d.err   = 1'b0;
                tmr_load  = 1'b1;
                tmr_len   = lpx_cyc_i;
            end
            PH_REQ: if (tmr_done) begin
                s_d.phase = PH_PREP;
                tmr_load  = 1'b1;
                tmr_len   = prep_cyc_i;
            end
            PH_PREP: if (tmr_done) begin
                s_d.phase = PH_ZERO;
                tmr_load  = 1'b1;
                tmr_len   = zero_cyc_i;
            end
            PH_ZERO: if (tmr_done) begin
                s_d.phase = PH_SYNC;
                sh_load   = 1'b1;
            end
            PH_SYNC, PH_PAY: begin
                s_d.prev = sh_bit;
                if (!sh_end) begin
                    sh_shift = 1'b1;
                end else if (take_slot && byte_valid_i) begin
                    s_d.phase = PH_PAY;
                    s_d.fin   = byte_last_i;
                    sh_load   = 1'b1;
                    sh_val    = byte_i;
                end else begin
                    s_d.err   = s_q.err | take_slot;
                    s_d.phase = PH_TRAIL;
                    tmr_load  = 1'b1;
                    tmr_len   = trail_cyc_i;
                end
            end
            PH_TRAIL: if (tmr_done) begin
                s_d.phase = PH_EXIT;
                tmr_load  = 1'b1;
                tmr_len   = exit_len;
            end
            PH_EXIT: if (tmr_done) s_d.phase = PH_IDLE;
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, fin: 1'b0, prev: 1'b0, err: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        unique case (s_q.phase)
            PH_REQ:          line_o = LN_REQ;
            PH_PREP:         line_o = LN_BRIDGE;
            PH_ZERO:         line_o = LN_HS0;
            PH_SYNC, PH_PAY: line_o = sh_bit ? LN_HS1 : LN_HS0;
            PH_TRAIL:        line_o = s_q.prev ? LN_HS0 : LN_HS1;
            default:         line_o = LN_STOP;
        endcase
    end

    assign byte_rdy_o = take_slot;
    assign busy_o     = (s_q.phase != PH_IDLE);
    assign err_o      = s_q.err;

    assert_start_enters_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (line_o == LN_REQ));

    assert_rdy_in_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rdy_o |-> (line_o == LN_HS0 || line_o == LN_HS1));

    assert_trail_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_TRAIL && $past(s_q.phase) != PH_TRAIL)
            |-> (line_o[0] != $past(line_o[0])));

    assert_err_on_underrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(byte_rdy_o && !byte_valid_i));

    assert_busy_not_restarted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.phase != PH_EXIT) |=> busy_o);
endmodule

// File: tb/test_dlane_burst_seq.sv
module test_dlane_burst_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic       byte_valid_i = 1'b0;
    logic       byte_last_i = 1'b0;
    logic       byte_rdy_o;
    logic [7:0] lpx_cyc_i = '0, prep_cyc_i = '0, zero_cyc_i = '0;
    logic [7:0] trail_cyc_i = '0, exit_cyc_i = '0;
    logic [2:0] line_o;
    logic       busy_o, err_o;

    int n_chk = 0;
    int n_fail = 0;
    int busy_cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] code;
        logic       busy;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    dlane_burst_seq i_dlane_burst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_i(byte_i),
        .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
        .byte_rdy_o(byte_rdy_o), .lpx_cyc_i(lpx_cyc_i), .prep_cyc_i(prep_cyc_i),
        .zero_cyc_i(zero_cyc_i), .trail_cyc_i(trail_cyc_i), .exit_cyc_i(exit_cyc_i),
        .line_o(line_o), .busy_o(busy_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_n(input logic [2:0] code, input logic busy, input int n,
                          input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t it;
            it.code = code; it.busy = busy; it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    // monitor: compare every cycle against the scoreboard queue
    always @(negedge clk) begin
        if (busy_o) busy_cyc++;
        if (exp_q.size() != 0) begin
            exp_t it;
            it = exp_q.pop_front();
            chk(line_o == it.code, {it.tag, " line"}, int'(line_o), int'(it.code));
            chk(busy_o == it.busy, {it.tag, " busy"}, int'(busy_o), int'(it.busy));
        end
    end

    function automatic int clamp1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    task automatic run_burst(input int l, input int p, input int z, input int t,
                             input int e, input logic [7:0] bytes[$],
                             input bit with_last, input bit pulses, input string len_tag);
        int   lp, xp, len;
        logic lastbit;
        lp = clamp1(l);
        xp = clamp1((e > l) ? e : l);
        len = lp + clamp1(p) + clamp1(z) + 8 + 8 * bytes.size() + clamp1(t) + xp;
        @(posedge clk); #1;
        lpx_cyc_i = 8'(l); prep_cyc_i = 8'(p); zero_cyc_i = 8'(z);
        trail_cyc_i = 8'(t); exit_cyc_i = 8'(e);
        byte_valid_i = (bytes.size() > 0);
        byte_i = (bytes.size() > 0) ? bytes[0] : 8'h00;
        byte_last_i = with_last && (bytes.size() == 1);
        start_i = 1'b1;
        busy_cyc = 0;
        push_n(3'd0, 1'b0, 1, "R1");
        push_n(3'd1, 1'b1, lp, "R2");
        push_n(3'd2, 1'b1, clamp1(p), "R3");
        push_n(3'd4, 1'b1, clamp1(z), "R4");
        for (int b = 0; b < 8; b++) push_n(8'hB8 >> b & 1 ? 3'd5 : 3'd4, 1'b1, 1, "R5");
        lastbit = 1'b1;
        foreach (bytes[k]) begin
            for (int b = 0; b < 8; b++) push_n(bytes[k][b] ? 3'd5 : 3'd4, 1'b1, 1, "R6");
            lastbit = bytes[k][7];
        end
        push_n(lastbit ? 3'd4 : 3'd5, 1'b1, clamp1(t), "R7");
        push_n(3'd0, 1'b1, xp, "R8");
        push_n(3'd0, 1'b0, 3, "R1");
        @(posedge clk); #1;
        start_i = 1'b0;
        fork
            begin : feeder
                foreach (bytes[k]) begin
                    do @(negedge clk); while (!byte_rdy_o);
                    @(posedge clk); #1;
                    if (k + 1 < bytes.size()) begin
                        byte_i = bytes[k+1];
                        byte_last_i = with_last && (k + 2 == bytes.size());
                    end else begin
                        byte_valid_i = 1'b0;
                        byte_last_i = 1'b0;
                    end
                end
            end
            begin : pulser
                if (pulses) begin
                    repeat (5) @(posedge clk); #1;
                    start_i = 1'b1;
                    @(posedge clk); #1;
                    start_i = 1'b0;
                    repeat (len - 7) @(posedge clk); #1;
                    start_i = 1'b1;
                    @(posedge clk); #1;
                    start_i = 1'b0;
                end
            end
        join
        while (exp_q.size() != 0) @(posedge clk);
        @(negedge clk);
        chk(err_o == !with_last, "R11 err flag", int'(err_o), int'(!with_last));
        chk(busy_cyc == len, len_tag, busy_cyc, len);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(line_o == 3'd0, "R1 reset line", int'(line_o), 0);
        chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
        chk(err_o == 1'b0, "R1 reset err", int'(err_o), 0);
        chk(byte_rdy_o == 1'b0, "R1 reset rdy", int'(byte_rdy_o), 0);

        // nominal two-byte burst, last bit 1
        run_burst(3, 2, 4, 5, 6, '{8'h3C, 8'hA5}, 1'b1, 1'b0, "R8 burst length");
        // all intervals zero: each clamps to one cycle
        run_burst(0, 0, 0, 0, 0, '{8'h81}, 1'b1, 1'b0, "R9 clamped length");
        // exit shorter than lpx, starts while busy ignored
        run_burst(4, 2, 3, 3, 2, '{8'hFF}, 1'b1, 1'b1, "R10 length with stray starts");
        // underrun after first byte, last bit 0 -> trail HS1
        run_burst(2, 1, 2, 2, 3, '{8'h01}, 1'b0, 1'b0, "R11 underrun length");
        // underrun at first slot, trail after sync
        run_burst(2, 3, 1, 4, 2, '{}, 1'b0, 1'b0, "R11 first-slot underrun length");
        // error cleared by next start, three bytes
        run_burst(1, 1, 1, 1, 1, '{8'h00, 8'h7E, 8'h55}, 1'b1, 1'b0, "R6 three-byte length");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule